// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block sits beside a synchronous memory core and manages its low-power state. An asynchronous sleep request is synchronized to the clock. The controller then walks the core into sleep through a fixed entry interval and back out through a fixed wake interval. From the first cycle of entry to the last cycle of wake, the core is blocked from taking accesses. Any access that is in flight when entry starts is not guaranteed to complete and is treated as lost. The stored contents are kept, because the block only gates access and never touches the array.

The controller also checks the select protocol around sleep. The memory has to be deselected when sleep is requested, and every chip select has to stay inactive for the whole wake window. If either rule is broken, a sticky error flag is raised and stays set until reset. If the request is withdrawn while entry is still in progress, the sequencer skips the sleep state and goes directly into the wake window.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no sleep request, `sleep_o`, `block_o` and `err_o` are all 0.
- R2: The sleep request passes through a two-stage synchronizer. A request that is stable before rising edge 1 raises `block_o` after rising edge 3, and not earlier.
- R3: Entry latency: `sleep_o` rises exactly two clock cycles after `block_o` rises, provided the request is held.
- R4: Exit latency: once the request is removed and has been stable before rising edge 1, `sleep_o` falls after rising edge 3.
- R5: Recovery: after `sleep_o` falls, `block_o` stays high for two further cycles and then falls. It is high in every state other than fully awake.
- R6: If the request is removed during entry, the sequencer goes to the recovery window without ever asserting `sleep_o`. For a request raised before edge 1 and dropped between edges 2 and 3, `block_o` rises after edge 3 and falls after edge 7.
- R7: If any bit of `sel_i` is 1 in the cycle where the synchronized request is first acted on while awake, `err_o` rises after that edge (edge 3 of the request).
- R8: If any bit of `sel_i` is 1 during the recovery window, `err_o` rises at the next rising edge.
- R9: `err_o` is sticky. It stays 1 until `rst_ni` is asserted, and reset clears it.
- R10: Asserting `sel_i` while fully asleep, or while awake with no request, has no effect on `err_o`, `sleep_o` or `block_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| sel_i | input | NUM_SEL | Chip selects, active high; any bit set means selected |
| sleep_o | output | 1 | Core is fully asleep |
| block_o | output | 1 | Access to the core is blocked |
| err_o | output | 1 | Sticky select-protocol violation |

## Verification
The hardest case to reach is the aborted entry of R6. Because of the two-flop synchronizer and the two-cycle entry count, withdrawing the request in exactly one clock slot reaches the state machine while it is still entering. One slot later, the sequencer falls asleep before it sees the withdrawal. The bench drives the request high before edge 1 and drops it between edges 2 and 3, so the falling synchronized request arrives in the final entry cycle. It then checks that `sleep_o` never rises and that `block_o` falls after edge 7.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE    = 2'd0,
    ST_ENTERING = 2'd1,
    ST_ASLEEP   = 2'd2,
    ST_RECOVER  = 2'd3
  } slp_state_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

  // R2
  sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(chain_q[STAGES-2]));
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 2,
  parameter int unsigned EXIT_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  output slp_state_e state_o
);
  localparam int unsigned MAX_CYC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  slp_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: begin
        cnt_d = '0;
        if (req_i) state_d = ST_ENTERING;
      end
      ST_ENTERING: begin
        // withdrawal beats completion
        if (!req_i) begin
          state_d = ST_RECOVER;
          cnt_d   = '0;
        end else if (cnt_q == ENTRY_LAST) begin
          state_d = ST_ASLEEP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ASLEEP: begin
        cnt_d = '0;
        if (!req_i) state_d = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (cnt_q == EXIT_LAST) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  // R3
  asleep_from_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASLEEP && $past(state_q) != ST_ASLEEP) |-> $past(state_q) == ST_ENTERING);

  // R5
  awake_from_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AWAKE && $past(state_q) != ST_AWAKE) |-> $past(state_q) == ST_RECOVER);

  // R4
  leave_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASLEEP && !req_i) |=> state_q == ST_RECOVER);
endmodule

// File: rtl/sleep_err.sv
module sleep_err #(
  parameter int unsigned NUM_SEL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_seen_i,
  input  logic               recover_i,
  input  logic [NUM_SEL-1:0] sel_i,
  output logic               err_o
);
  logic err_q;
  logic sel_any;
  logic violation;

  assign sel_any   = |sel_i;
  assign violation = sel_any & (req_seen_i | recover_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        err_q <= 1'b0;
    else if (violation) err_q <= 1'b1;

  assign err_o = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  // R8
  recover_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recover_i && sel_any) |=> err_q);

  // R10
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(sel_any));
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_pkg::*;
#(
  parameter int unsigned NUM_SEL     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ENTRY_CYC   = 2,
  parameter int unsigned EXIT_CYC    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic [NUM_SEL-1:0] sel_i,
  output logic               sleep_o,
  output logic               block_o,
  output logic               err_o
);
  logic       req_sync;
  slp_state_e state;

  sleep_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (req_sync)
  );

  sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_sync),
    .state_o(state)
  );

  sleep_err #(.NUM_SEL(NUM_SEL)) i_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_seen_i(req_sync && state == ST_AWAKE),
    .recover_i (state == ST_RECOVER),
    .sel_i     (sel_i),
    .err_o     (err_o)
  );

  assign sleep_o = (state == ST_ASLEEP);
  assign block_o = (state != ST_AWAKE);

  // R5
  sleep_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> block_o);

  // R3
  entry_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> ($past(block_o) && $past(block_o, 2)));

  // R5
  exit_keeps_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> block_o);
endmodule

// File: tb/test_sleep_seq_ctrl.sv
module test_sleep_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEL    = 3;

  logic               clk = 1'b0;
  logic               rst_ni;
  logic               sleep_req;
  logic [NUM_SEL-1:0] sel;
  logic               sleep_w, block_w, err_w;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_seq_ctrl #(.NUM_SEL(NUM_SEL)) i_sleep_seq_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req),
    .sel_i      (sel),
    .sleep_o    (sleep_w),
    .block_o    (block_w),
    .err_o      (err_w)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; sleep_req = 1'b0; sel = '0;
    step(2);
    check(sleep_w, 1'b0, "R1 sleep in reset");
    check(block_w, 1'b0, "R1 block in reset");
    check(err_w,   1'b0, "R1 err in reset");
    rst_ni = 1'b1;
    step(2);
    check(sleep_w, 1'b0, "R1 sleep after reset");
    check(block_w, 1'b0, "R1 block after reset");
    check(err_w,   1'b0, "R1 err after reset");
  endtask

  // full sleep and wake cycle; sel may be pulsed while asleep
  task automatic t_cycle(input logic poke_asleep);
    sleep_req = 1'b1;
    step(2);
    check(block_w, 1'b0, "R2 block before edge 3");
    step(1);
    check(block_w, 1'b1, "R2 block after edge 3");
    check(sleep_w, 1'b0, "R3 sleep at edge 3");
    step(1);
    check(sleep_w, 1'b0, "R3 sleep at edge 4");
    step(1);
    check(sleep_w, 1'b1, "R3 sleep at edge 5");
    if (poke_asleep) begin
      sel = '1;
      step(3);
      sel = '0;
      check(err_w,   1'b0, "R10 err with sel while asleep");
      check(sleep_w, 1'b1, "R10 sleep with sel while asleep");
    end
    sleep_req = 1'b0;
    step(2);
    check(sleep_w, 1'b1, "R4 sleep before edge 3");
    step(1);
    check(sleep_w, 1'b0, "R4 sleep after edge 3");
    check(block_w, 1'b1, "R5 block in recovery 1");
    step(1);
    check(block_w, 1'b1, "R5 block in recovery 2");
    step(1);
    check(block_w, 1'b0, "R5 block released");
    check(err_w,   1'b0, "R5 no error on clean cycle");
  endtask

  task automatic t_abort();
    logic saw_sleep = 1'b0;
    sleep_req = 1'b1;
    step(2);
    sleep_req = 1'b0;
    step(1);
    check(block_w, 1'b1, "R6 block after edge 3");
    for (int i = 4; i <= 7; i++) begin
      step(1);
      if (sleep_w) saw_sleep = 1'b1;
      if (i == 6) check(block_w, 1'b1, "R6 block at edge 6");
    end
    check(saw_sleep, 1'b0, "R6 sleep never asserted");
    check(block_w,   1'b0, "R6 block released after edge 7");
  endtask

  task automatic t_req_err();
    sel = 3'b010;
    step(2);
    check(err_w, 1'b0, "R10 sel while awake without request");
    sleep_req = 1'b1;
    step(2);
    check(err_w, 1'b0, "R7 err before edge 3");
    step(1);
    check(err_w, 1'b1, "R7 err after edge 3");
    sel = '0;
    sleep_req = 1'b0;
    step(8);
    check(err_w, 1'b1, "R9 err held");
    check(block_w, 1'b0, "R9 sequencer back awake");
  endtask

  task automatic t_rec_err();
    sleep_req = 1'b1;
    step(6);
    sleep_req = 1'b0;
    step(3);
    check(block_w, 1'b1, "R8 in recovery");
    check(err_w,   1'b0, "R8 err before sel");
    sel = 3'b100;
    step(1);
    sel = '0;
    check(err_w, 1'b1, "R8 err after sel in recovery");
    step(4);
    check(err_w, 1'b1, "R9 err sticky");
    rst_ni = 1'b0;
    step(1);
    check(err_w, 1'b0, "R9 reset clears err");
    rst_ni = 1'b1;
    step(1);
  endtask

  initial begin
    do_reset();
    t_cycle(1'b0);
    step(3);
    t_cycle(1'b1);
    step(3);
    t_abort();
    step(3);
    t_req_err();
    do_reset();
    t_rec_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule